// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

This block is a four-bit synchronous counter whose modulus is chosen at run time. It counts over the full sixteen binary states or over the ten BCD states, and it counts up or down. A level-sensitive preset copies a four-bit parallel value into the state without waiting for a clock edge. An active-low carry input serves as the count enable.

An active-low carry output marks the terminal count for the present direction. That output depends only on the current state, the two mode inputs and the carry input. Connecting one stage's carry output to the next stage's carry input therefore builds wider decimal or binary counters, and the whole chain settles within one clock period.

Illegal BCD states reached through the preset are tolerated. Counting up from any of them returns to zero. Counting down from one of them steps down one at a time until the state is inside the decade range again.

Top module: `jam_updown_counter`

## Requirements
- R1: While presetEn is high, q takes the value on jam without any clock edge and keeps it across clock edges; jam = 0 with presetEn high gives q = 0.
- R2: On a rising clock edge q changes only when carryInN = 0 and presetEn = 0; with carryInN = 1 the state holds.
- R3: With binMode = 1 and upMode = 1 each enabled edge adds one modulo 16 (15 goes to 0).
- R4: With binMode = 1 and upMode = 0 each enabled edge subtracts one modulo 16 (0 goes to 15).
- R5: With binMode = 0 counting up goes from 9 to 0, and counting down goes from 0 to 9.
- R6: With binMode = 0, counting up from any state 10 to 15 gives 0, and counting down from any state 10 to 15 subtracts one.
- R7: carryOutN is 0 exactly when carryInN = 0 and either upMode = 1 with q at its maximum (15 binary, 9 decade) or upMode = 0 with q = 0. It follows its inputs without a clock edge.
- R8: After presetEn falls, the first rising edge with carryInN = 0 advances from the loaded value.
- R9: rstN low clears q to 0 at once, without a clock edge.
- R10: Two stages, the second with its carryInN driven by the first stage's carryOutN, count the sequences 0 to 99 (decade) and 0 to 255 (binary) in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| carryInN | input | 1 | Count enable and cascade carry, active low |
| presetEn | input | 1 | Asynchronous parallel load, active high |
| binMode | input | 1 | 1 selects modulo 16, 0 selects modulo 10 |
| upMode | input | 1 | 1 counts up, 0 counts down |
| jam | input | 4 | Parallel load value |
| q | output | 4 | Counter state |
| carryOutN | output | 1 | Terminal-count flag, active low, gated by carryInN |

## Verification
The hardest case to provoke is a decade-mode counter sitting in an illegal state (10 to 15) when an edge arrives. A plain count from zero never gets there. The bench reaches those states only through a random preset with binMode low, or by switching binMode from 1 to 0 while the binary count is above 9. The random phase mixes both, and directed cases start an up count and a down count from 12. The cascade runs change the upper stage only through the combinational carry chain, so they show that the carry output is valid before the shared edge.

// File: rtl/jam_cnt_pkg.sv
package jam_cnt_pkg;
  localparam int CW = 4;
  localparam logic [CW-1:0] BIN_TOP = CW'((1 << CW) - 1);
  localparam logic [CW-1:0] DEC_TOP = CW'(9);

  typedef struct packed {
    logic          advance;
    logic          countUp;
    logic          wrap;
    logic [CW-1:0] wrapVal;
  } ctrl_t;
endpackage

// File: rtl/jam_cnt_ctrl.sv
module jam_cnt_ctrl
  import jam_cnt_pkg::*;
(
  input  logic [CW-1:0] cnt,
  input  logic          carryInN,
  input  logic          presetEn,
  input  logic          binMode,
  input  logic          upMode,
  output ctrl_t         strobe,
  output logic          carryOutN
);
  logic [CW-1:0] topVal;
  logic          atTerm;
  logic          wrapHit;

  always_comb begin
    topVal = binMode ? BIN_TOP : DEC_TOP;
    if (upMode) begin
      atTerm  = (cnt == topVal);
      wrapHit = binMode ? (cnt == BIN_TOP) : (cnt >= DEC_TOP);
    end else begin
      atTerm  = (cnt == '0);
      wrapHit = (cnt == '0);
    end
  end

  always_comb begin
    strobe.advance = !carryInN && !presetEn;
    strobe.countUp = upMode;
    strobe.wrap    = wrapHit;
    strobe.wrapVal = upMode ? '0 : topVal;
    carryOutN      = !(atTerm && !carryInN);
  end
endmodule

// File: rtl/jam_cnt_dp.sv
module jam_cnt_dp
  import jam_cnt_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          presetEn,
  input  logic [CW-1:0] jam,
  input  ctrl_t         strobe,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] stepVal;

  always_comb begin
    if (strobe.wrap)        stepVal = strobe.wrapVal;
    else if (strobe.countUp) stepVal = cnt + CW'(1);
    else                     stepVal = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rstN or posedge presetEn) begin
    if (!rstN)               cnt <= '0;
    else if (presetEn)       cnt <= jam;
    else if (strobe.advance) cnt <= stepVal;
  end
endmodule

// File: rtl/jam_updown_counter.sv
module jam_updown_counter
  import jam_cnt_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          carryInN,
  input  logic          presetEn,
  input  logic          binMode,
  input  logic          upMode,
  input  logic [CW-1:0] jam,
  output logic [CW-1:0] q,
  output logic          carryOutN
);
  ctrl_t strobe;

  jam_cnt_ctrl u_ctrl (
    .cnt(q), .carryInN(carryInN), .presetEn(presetEn), .binMode(binMode),
    .upMode(upMode), .strobe(strobe), .carryOutN(carryOutN)
  );

  jam_cnt_dp u_dp (
    .clk(clk), .rstN(rstN), .presetEn(presetEn), .jam(jam),
    .strobe(strobe), .cnt(q)
  );
endmodule

// File: rtl/jam_cnt_chk.sv
module jam_cnt_chk
  import jam_cnt_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          carryInN,
  input logic          presetEn,
  input logic          binMode,
  input logic          upMode,
  input logic [CW-1:0] jam,
  input logic [CW-1:0] q,
  input logic          carryOutN
);
  // R1
  preset_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    presetEn |-> (q == jam));

  // R2
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rstN || presetEn)
    carryInN |=> (q == $past(q)));

  // R3
  bin_up_chk: assert property (@(posedge clk) disable iff (!rstN || presetEn)
    (!carryInN && binMode && upMode) |=> (q == CW'($past(q) + CW'(1))));

  // R4
  bin_down_chk: assert property (@(posedge clk) disable iff (!rstN || presetEn)
    (!carryInN && binMode && !upMode) |=> (q == CW'($past(q) - CW'(1))));

  // R5
  dec_wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN || presetEn)
    (!carryInN && !binMode && upMode && q == DEC_TOP) |=> (q == '0));

  // R6
  dec_illegal_up_chk: assert property (@(posedge clk) disable iff (!rstN || presetEn)
    (!carryInN && !binMode && upMode && q > DEC_TOP) |=> (q == '0));

  // R7
  carry_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !carryOutN |-> !carryInN);

  // R7
  carry_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!carryInN && !upMode && q == '0) |-> !carryOutN);
endmodule

bind jam_updown_counter jam_cnt_chk u_chk (
  .clk(clk), .rstN(rstN), .carryInN(carryInN), .presetEn(presetEn),
  .binMode(binMode), .upMode(upMode), .jam(jam), .q(q), .carryOutN(carryOutN)
);

// File: tb/jam_updown_counter_bench.sv
`timescale 1ns/100ps
module jam_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       carryInN = 1'b1;
  logic       presetEn = 1'b0;
  logic       binMode = 1'b1;
  logic       upMode = 1'b1;
  logic [3:0] jam = 4'd0;
  logic [3:0] q, qHi;
  logic       carryOutN, carryOutHiN;

  int errors = 0;
  int checks = 0;
  logic [3:0] mq;

  always #2 clk = ~clk;

  jam_updown_counter u_jam_updown_counter (
    .clk(clk), .rstN(rstN), .carryInN(carryInN), .presetEn(presetEn),
    .binMode(binMode), .upMode(upMode), .jam(jam), .q(q), .carryOutN(carryOutN)
  );

  jam_updown_counter u_hi (
    .clk(clk), .rstN(rstN), .carryInN(carryOutN), .presetEn(presetEn),
    .binMode(binMode), .upMode(upMode), .jam(jam), .q(qHi), .carryOutN(carryOutHiN)
  );

  function automatic logic [3:0] nextRef(logic [3:0] v, logic bin, logic up);
    if (up) return bin ? 4'(v + 4'd1) : ((v >= 4'd9) ? 4'd0 : 4'(v + 4'd1));
    else    return (v == 4'd0) ? (bin ? 4'd15 : 4'd9) : 4'(v - 4'd1);
  endfunction

  function automatic logic coutRef(logic [3:0] v, logic bin, logic up, logic cin);
    logic term;
    term = up ? (v == (bin ? 4'd15 : 4'd9)) : (v == 4'd0);
    return !(term && !cin);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkState(string req);
    check(req, q, mq);
    check("R7", carryOutN, coutRef(mq, binMode, upMode, carryInN));
  endtask

  task automatic presetBoth(logic [3:0] v);
    jam = v;
    #0.5 presetEn = 1'b1;
    #0.5;
    check("R1", q, v);
    tick();
    check("R1", q, v);
    presetEn = 1'b0;
    mq = v;
  endtask

  task automatic cascadeRun(logic bin, logic up, int modulus);
    int base;
    int val;
    base = bin ? 16 : 10;
    binMode = bin;
    upMode = up;
    carryInN = 1'b1;
    presetBoth(4'd0);
    carryInN = 1'b0;
    for (int i = 1; i <= modulus; i++) begin
      tick();
      val = up ? (i % modulus) : ((modulus - i) % modulus);
      check("R10", int'(qHi) * base + int'(q), val);
    end
    carryInN = 1'b1;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick();
    check("R9", q, 0);
    rstN = 1'b1;
    mq = 4'd0;
    tick();
    check("R2", q, 0);

    // R1 zero preset, R8 resume
    presetBoth(4'd0);
    presetBoth(4'd5);
    binMode = 1'b1; upMode = 1'b1; carryInN = 1'b0;
    tick(); mq = 4'd6; checkState("R8");

    // R3 / R4 wrap
    carryInN = 1'b1;
    presetBoth(4'd15);
    check("R7", carryOutN, 1);
    carryInN = 1'b0; #0.5;
    check("R7", carryOutN, 0);
    tick(); mq = 4'd0; checkState("R3");
    upMode = 1'b0; #0.5;
    check("R7", carryOutN, 0);
    tick(); mq = 4'd15; checkState("R4");

    // R5 decade wraps
    binMode = 1'b0; upMode = 1'b1; carryInN = 1'b1;
    presetBoth(4'd9);
    carryInN = 1'b0;
    tick(); mq = 4'd0; checkState("R5");
    upMode = 1'b0;
    tick(); mq = 4'd9; checkState("R5");

    // R6 illegal decade states
    carryInN = 1'b1;
    presetBoth(4'd12);
    upMode = 1'b1; carryInN = 1'b0;
    tick(); mq = 4'd0; checkState("R6");
    carryInN = 1'b1;
    presetBoth(4'd12);
    upMode = 1'b0; carryInN = 1'b0;
    tick(); mq = 4'd11; checkState("R6");

    // R2 hold with carryInN high
    carryInN = 1'b1;
    tick(); tick(); checkState("R2");

    // R9 async clear mid-run
    #0.5 rstN = 1'b0; #0.5;
    check("R9", q, 0);
    tick(); rstN = 1'b1; mq = 4'd0;

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      binMode = ($urandom_range(0, 3) != 0) ? binMode : ~binMode;
      upMode = ($urandom_range(0, 4) != 0) ? upMode : ~upMode;
      if (r == 0) begin
        carryInN = 1'b1;
        presetBoth(4'($urandom_range(0, 15)));
      end else begin
        carryInN = (r < 3);
        #0.5;
        check("R7", carryOutN, coutRef(mq, binMode, upMode, carryInN));
        tick();
        if (!carryInN) mq = nextRef(mq, binMode, upMode);
        checkState(carryInN ? "R2" : (binMode ? "R3" : "R5"));
      end
    end

    // R10 cascades
    cascadeRun(1'b0, 1'b1, 100);
    cascadeRun(1'b0, 1'b0, 100);
    cascadeRun(1'b1, 1'b1, 256);
    cascadeRun(1'b1, 1'b0, 256);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule